// File: doc/BRIEF.md
# Masked transmit endpoint event aggregator

This block gathers the transmit status of up to four endpoints into one byte-wide event register and raises a single masked summary interrupt. Each endpoint supplies three one-clock pulses: one when an IN transfer completes, one when its transmit FIFO runs dry, and one when the CPU reads that endpoint's own status register. The low nibble of the event register holds the completion flags. The high nibble holds the underrun flags. Endpoint n sits at the same position in both nibbles.

The event flags are cleared only by the per-endpoint status-read pulses. Reading the event register has no side effect, and the CPU cannot write it. A read/write mask register uses the same bit layout. The summary output is high whenever any event bit and its mask bit are both set. Endpoints that are built as store-and-forward cannot underrun, so their underrun flag is fixed at zero. By default this applies to endpoint 0.

Top module: `tx_event_aggr`

## Requirements
- R1: After reset, both the event register (address 0) and the mask register (address 1) read 0x00, and `ev_irq` is low.
- R2: A pulse on `ep_done_set[n]` sets event bit n, which is visible on the first rising edge after the pulse.
- R3: A pulse on `ep_urun_set[n]` sets event bit 4+n for every endpoint n that is not store-and-forward.
- R4: Event bit 4 (the endpoint 0 underrun) always reads 0, even after a pulse on `ep_urun_set[0]`.
- R5: A pulse on `ep_stat_rd[n]` clears event bits n and 4+n and leaves all other bits unchanged.
- R6: When a set pulse and a status-read pulse for the same endpoint arrive in the same cycle, the set wins and the bit ends up set.
- R7: A write to address 0 changes neither the event register nor the mask register.
- R8: A write to address 1 stores `reg_wdata` in the mask register, and that value reads back at address 1.
- R9: `ev_irq` equals the OR over all bits of (event AND mask). A mask write takes effect on `ev_irq` right after the rising edge that captures it, and not before that edge.
- R10: Reading the event register does not clear any event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ep_done_set | input | NUM_EP | Per-endpoint IN-transfer-complete pulse |
| ep_urun_set | input | NUM_EP | Per-endpoint transmit FIFO underflow pulse |
| ep_stat_rd | input | NUM_EP | Per-endpoint status-register read strobe; clears that endpoint's flags |
| reg_addr | input | 1 | Register select: 0 = event, 1 = mask |
| reg_wr_en | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| ev_irq | output | 1 | Masked summary event |

## Verification
The assertions assume that every endpoint pulse and every register write is a clean, one-clock, synchronous event with known values once reset is released. The hold and stability properties also assume that no endpoint input stays high across edges when the bench does not intend it. To stay within these assumptions, the stimulus changes inputs only on falling edges and lowers every pulse one nanosecond after the rising edge that consumes it. Registers are read back by moving `reg_addr` only while the write enable is low.

// File: rtl/txev_pkg.sv
package txev_pkg;

   localparam int NIB_W = 4;
   localparam int REG_W = 2 * NIB_W;

   typedef logic [REG_W-1:0] txev_byte_t;

   typedef enum logic {
      ADDR_EVENT = 1'b0,
      ADDR_MASK  = 1'b1
   } txev_addr_e;

endpackage

// File: rtl/txev_ep_slice.sv
module txev_ep_slice #(
   parameter bit STORE_FWD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done_set,
   input  logic urun_set,
   input  logic stat_rd,
   output logic done_q,
   output logic urun_q
);

   // set beats clear when both arrive in one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (done_set) begin
         done_q <= 1'b1;
      end else if (stat_rd) begin
         done_q <= 1'b0;
      end
   end

   p_done_set_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> done_q);
   p_done_clr_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done_set) |=> !done_q);
   p_done_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !stat_rd) |=> done_q);

   generate
      if (STORE_FWD) begin : g_store_fwd
         logic urun_unused;
         assign urun_unused = urun_set;
         assign urun_q      = 1'b0;
      end else begin : g_streaming
         logic urun_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               urun_r <= 1'b0;
            end else if (urun_set) begin
               urun_r <= 1'b1;
            end else if (stat_rd) begin
               urun_r <= 1'b0;
            end
         end
         assign urun_q = urun_r;

         p_urun_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            urun_set |=> urun_q);
         p_urun_clr_r5 : assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && !urun_set) |=> !urun_q);
         p_urun_win_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && urun_set) |=> urun_q);
      end
   endgenerate

endmodule

// File: rtl/txev_mask_reg.sv
module txev_mask_reg
   import txev_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  txev_byte_t wdata,
   output txev_byte_t mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en) begin
         mask_q <= wdata;
      end
   end

   p_mask_wr_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q == $past(wdata)));
   p_mask_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/txev_rd_mux.sv
module txev_rd_mux
   import txev_pkg::*;
(
   input  logic       addr,
   input  txev_byte_t event_v,
   input  txev_byte_t mask_v,
   output txev_byte_t rdata
);

   always_comb begin
      unique case (addr)
         ADDR_EVENT: rdata = event_v;
         default:    rdata = mask_v;
      endcase
   end

endmodule

// File: rtl/tx_event_aggr.sv
module tx_event_aggr
   import txev_pkg::*;
#(
   parameter int              NUM_EP     = 4,
   parameter logic [NUM_EP-1:0] SF_EP_MASK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] ep_done_set,
   input  logic [NUM_EP-1:0] ep_urun_set,
   input  logic [NUM_EP-1:0] ep_stat_rd,
   input  logic              reg_addr,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              ev_irq
);

   generate
      if (NUM_EP < 1 || NUM_EP > NIB_W) begin : g_bad_num_ep
         $error("tx_event_aggr: NUM_EP must lie in 1..%0d", NIB_W);
      end
   endgenerate

   logic [NIB_W-1:0] done_vec;
   logic [NIB_W-1:0] urun_vec;
   txev_byte_t       event_v;
   txev_byte_t       mask_v;
   logic             mask_wr;

   genvar i;
   generate
      for (i = 0; i < NIB_W; i++) begin : g_ep
         if (i < NUM_EP) begin : g_live
            txev_ep_slice #(
               .STORE_FWD (SF_EP_MASK[i])
            ) slice_i (
               .clk      (clk),
               .rst_n    (rst_n),
               .done_set (ep_done_set[i]),
               .urun_set (ep_urun_set[i]),
               .stat_rd  (ep_stat_rd[i]),
               .done_q   (done_vec[i]),
               .urun_q   (urun_vec[i])
            );
         end else begin : g_absent
            assign done_vec[i] = 1'b0;
            assign urun_vec[i] = 1'b0;
         end
      end
   endgenerate

   assign event_v = {urun_vec, done_vec};
   assign mask_wr = reg_wr_en && (reg_addr == ADDR_MASK);

   txev_mask_reg mask_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_wr),
      .wdata  (reg_wdata),
      .mask_q (mask_v)
   );

   txev_rd_mux rd_i (
      .addr    (reg_addr),
      .event_v (event_v),
      .mask_v  (mask_v),
      .rdata   (reg_rdata)
   );

   assign ev_irq = |(event_v & mask_v);

   // the event byte only moves in response to endpoint pulses (R7, R10)
   p_ev_ro_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!(|ep_done_set) && !(|ep_urun_set) && !(|ep_stat_rd)) |=> $stable(event_v));

   // clearing the mask silences the summary on the next clock
   p_irq_off_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_MASK && reg_wdata == '0) |=> !ev_irq);

   generate
      if (SF_EP_MASK[0]) begin : g_chk_sf0
         p_urun0_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == ADDR_EVENT) |-> (reg_rdata[NIB_W] == 1'b0));
      end
   endgenerate

endmodule

// File: tb/tx_event_aggr_tb_top.sv
module tx_event_aggr_tb_top;

   typedef struct packed {
      logic [3:0] done;
      logic [3:0] urun;
      logic [3:0] rd;
      logic       wr;
      logic       addr;
      logic [7:0] wdata;
      logic [7:0] exp_ev;
      logic [7:0] exp_mask;
      logic       exp_irq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 1'b0}, // R2 ep0 done
      '{4'h0, 4'h1, 4'h0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 1'b0}, // R4 ep0 urun ignored
      '{4'h0, 4'h4, 4'h0, 1'b0, 1'b0, 8'h00, 8'h41, 8'h00, 1'b0}, // R3 ep2 urun
      '{4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 8'h40, 8'h41, 8'h40, 1'b1}, // R8 R9 mask write
      '{4'h0, 4'h0, 4'h4, 1'b0, 1'b0, 8'h00, 8'h01, 8'h40, 1'b0}, // R5 ep2 read
      '{4'h4, 4'h0, 4'h4, 1'b0, 1'b0, 8'h00, 8'h05, 8'h40, 1'b0}, // R6 done vs read
      '{4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 8'hFF, 8'h05, 8'h40, 1'b0}, // R7 event write
      '{4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 8'h04, 8'h05, 8'h04, 1'b1}, // R8 R9
      '{4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 8'h00, 8'h04, 8'h04, 1'b1}, // R5 ep0 read
      '{4'h8, 4'h8, 4'h0, 1'b0, 1'b0, 8'h00, 8'h8C, 8'h04, 1'b1}, // R2 R3 ep3
      '{4'h0, 4'h0, 4'hC, 1'b0, 1'b0, 8'h00, 8'h00, 8'h04, 1'b0}, // R5 two reads
      '{4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, 1'b0}, // R8 R9 no events
      '{4'h0, 4'hE, 4'h0, 1'b0, 1'b0, 8'h00, 8'hE0, 8'hFF, 1'b1}, // R3 three urun
      '{4'h0, 4'h0, 4'hF, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b0}, // R5 all read
      '{4'h0, 4'h2, 4'h2, 1'b0, 1'b0, 8'h00, 8'h20, 8'hFF, 1'b1}  // R6 urun vs read
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ep_done_set = '0;
   logic [3:0] ep_urun_set = '0;
   logic [3:0] ep_stat_rd = '0;
   logic       reg_addr = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ev_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tx_event_aggr dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ep_done_set (ep_done_set),
      .ep_urun_set (ep_urun_set),
      .ep_stat_rd  (ep_stat_rd),
      .reg_addr    (reg_addr),
      .reg_wr_en   (reg_wr_en),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .ev_irq      (ev_irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic read_reg(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic check_state(input string tag, input logic [7:0] ev,
                              input logic [7:0] mk, input logic irq);
      logic [7:0] v;
      read_reg(1'b0, v);
      check({tag, " event"}, v, ev);
      read_reg(1'b1, v);
      check({tag, " mask"}, v, mk);
      check({tag, " irq R9"}, {7'd0, ev_irq}, {7'd0, irq});
   endtask

   initial begin : watchdog
      #500000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset", 8'h00, 8'h00, 1'b0);

      // table walk: pulses live for one rising edge; event read repeated (R10)
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         ep_done_set = VECS[k].done;
         ep_urun_set = VECS[k].urun;
         ep_stat_rd  = VECS[k].rd;
         reg_wr_en   = VECS[k].wr;
         reg_addr    = VECS[k].addr;
         reg_wdata   = VECS[k].wdata;
         @(posedge clk);
         #1;
         ep_done_set = '0;
         ep_urun_set = '0;
         ep_stat_rd  = '0;
         reg_wr_en   = 1'b0;
         check_state("R2 R3 R4 R5 R6 R7 R8 R10 vec", VECS[k].exp_ev,
                     VECS[k].exp_mask, VECS[k].exp_irq);
      end

      // R10: a further idle cycle with event reads keeps the byte
      @(negedge clk);
      read_reg(1'b0, v);
      @(negedge clk);
      read_reg(1'b0, v);
      check("R10 read keeps event", v, 8'h20);

      // R9 latency: mask cleared, irq still high until the capturing edge
      @(negedge clk);
      reg_addr  = 1'b1;
      reg_wdata = 8'h00;
      reg_wr_en = 1'b1;
      #1;
      check("R9 before edge", {7'd0, ev_irq}, 8'h01);
      @(posedge clk);
      #1;
      reg_wr_en = 1'b0;
      check("R9 after edge", {7'd0, ev_irq}, 8'h00);

      // R1 mid-run reset clears both registers
      @(negedge clk);
      reg_addr  = 1'b1;
      reg_wdata = 8'hFF;
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      rst_n = 1'b0;
      #1;
      check_state("R1 async reset", 8'h00, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule